// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a 32x32 two-plane cursor over a stream of display pixels. Software programs the cursor through a small word-addressed register port. It writes a position word, 32 row words of an opacity mask and 32 row words of colour-select bits. The same port holds a general status word.

On the video side, the block receives the screen coordinate currently being produced, the screen width and the colour that the frame buffer supplies for that coordinate. One clock later it returns either that colour or one of two cursor colours. The two cursor colours come from an external palette. The cursor is clipped at the right edge of the screen. Reset parks the cursor off-screen, so the picture is unchanged until software moves it.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, the cursor x coordinate is 0xF000, which places the cursor off-screen for any width up to 0xF000. `pix_out` reads 0 until the first pixel is clocked in. The status word reads 0x0200_0000.
- R2: A write to offset 0x818 stores the status word. A read at that offset returns the stored word with bit 25 forced to 1.
- R3: A write to offset 0x8FC sets the cursor x coordinate from data bits 31:16 and the cursor y coordinate from data bits 15:0.
- R4: The cursor covers screen rows `cur_y` through `cur_y`+31. Row word number `y - cur_y` applies to screen row y.
- R5: Within a row word, bit 31 is the pixel at x = `cur_x`, and each pixel further right uses the next lower bit. The pixel at x = `cur_x`+31 uses bit 0.
- R6: A mask bit of 0 is transparent. In that case, and anywhere outside the cursor, `pix_out` equals `pix_in`.
- R7: Where the mask bit is 1, a colour-select bit of 1 outputs `cur_col_hi` and a colour-select bit of 0 outputs `cur_col_lo`.
- R8: The cursor shows only when `cur_x` < `scr_width` and only at x < `scr_width`. This limits each row to min(width - `cur_x`, 32) pixels.
- R9: `pix_out` is registered. It reflects the coordinate and colours presented one clock earlier.
- R10: Mask rows are written at offsets 0x900 to 0x97F and colour-select rows at 0x980 to 0x9FF. The row number is (offset - base) >> 2. Writes to any other offset change nothing. Reads at any offset other than 0x818 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| scr_width | input | 16 | Visible screen width in pixels |
| vid_x | input | 16 | Current pixel column |
| vid_y | input | 16 | Current pixel row |
| pix_in | input | 24 | Underlying pixel colour |
| cur_col_lo | input | 24 | Cursor colour for select bit 0 |
| cur_col_hi | input | 24 | Cursor colour for select bit 1 |
| pix_out | output | 24 | Mixed pixel colour, one clock after input |

## Verification
The mixed pixel is due at the first rising edge after its coordinate and colours are presented. The bench therefore drives each coordinate at a falling edge and compares `pix_out` at the next falling edge, before it drives the following coordinate. Register writes take effect at the edge that samples the strobe, so every sweep starts at least one full cycle after its last write. Read data is combinational: the bench sets the offset at a falling edge and compares it a nanosecond later, within the same cycle.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  localparam int CUR_N = 32;
  localparam int IDX_W = $clog2(CUR_N);
  localparam int CRD_W = 16;

  typedef enum logic [1:0] {
    SEL_PASS = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } pix_sel_e;

  // true when v lies in [base, base + CUR_N), computed without wrap
  function automatic logic in_span(input logic [CRD_W-1:0] v,
                                   input logic [CRD_W-1:0] base);
    logic [CRD_W:0] lim;
    lim = {1'b0, base} + (CRD_W+1)'(CUR_N);
    return ({1'b0, v} >= {1'b0, base}) && ({1'b0, v} < lim);
  endfunction

  function automatic logic [IDX_W-1:0] offs(input logic [CRD_W-1:0] v,
                                            input logic [CRD_W-1:0] base);
    logic [CRD_W-1:0] d;
    d = v - base;
    return d[IDX_W-1:0];
  endfunction

  // column 0 is the most significant bit of the row word
  function automatic logic msb_pick(input logic [CUR_N-1:0] w,
                                    input logic [IDX_W-1:0] col);
    logic [IDX_W-1:0] pos;
    pos = IDX_W'(CUR_N - 1) - col;
    return w[pos];
  endfunction
endpackage

// File: rtl/cursor_ovl_regs.sv
module cursor_ovl_regs
  import cursor_ovl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] POS_OFF   = 12'h8fc,
  parameter logic [ADDR_W-1:0] MISC_OFF  = 12'h818,
  parameter logic [ADDR_W-1:0] MASK_BASE = 12'h900,
  parameter logic [ADDR_W-1:0] BITS_BASE = 12'h980,
  parameter logic [CRD_W-1:0]  PARK_X    = 16'hf000,
  parameter int MISC_FORCE_BIT = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [IDX_W-1:0]  row_sel,
  output logic [CRD_W-1:0]  cur_x,
  output logic [CRD_W-1:0]  cur_y,
  output logic [CUR_N-1:0]  mask_word,
  output logic [CUR_N-1:0]  bits_word
);
  localparam int SPAN = CUR_N * 4;
  localparam logic [ADDR_W-1:0] MASK_TOP = ADDR_W'(int'(MASK_BASE) + SPAN - 1);
  localparam logic [ADDR_W-1:0] BITS_TOP = ADDR_W'(int'(BITS_BASE) + SPAN - 1);
  localparam logic [DATA_W-1:0] FORCE_MASK = DATA_W'(1) << MISC_FORCE_BIT;

  logic [CUR_N-1:0]  mask_q [CUR_N];
  logic [CUR_N-1:0]  bits_q [CUR_N];
  logic [DATA_W-1:0] misc_q;
  logic [ADDR_W-1:0] mask_off, bits_off;
  logic              mask_wr, bits_wr;

  assign mask_off = addr - MASK_BASE;
  assign bits_off = addr - BITS_BASE;
  assign mask_wr  = we && (addr >= MASK_BASE) && (addr <= MASK_TOP);
  assign bits_wr  = we && (addr >= BITS_BASE) && (addr <= BITS_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_x  <= PARK_X;
      cur_y  <= '0;
      misc_q <= '0;
    end else if (we) begin
      if (addr == POS_OFF) begin
        cur_x <= wdata[2*CRD_W-1:CRD_W];
        cur_y <= wdata[CRD_W-1:0];
      end
      if (addr == MISC_OFF) misc_q <= wdata;
    end
  end

  for (genvar r = 0; r < CUR_N; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[r] <= '0;
        bits_q[r] <= '0;
      end else begin
        if (mask_wr && mask_off[IDX_W+1:2] == IDX_W'(r)) mask_q[r] <= wdata[CUR_N-1:0];
        if (bits_wr && bits_off[IDX_W+1:2] == IDX_W'(r)) bits_q[r] <= wdata[CUR_N-1:0];
      end
    end
  end

  assign mask_word = mask_q[row_sel];
  assign bits_word = bits_q[row_sel];
  assign rdata     = (addr == MISC_OFF) ? (misc_q | FORCE_MASK) : '0;
endmodule

// File: rtl/cursor_ovl_hit.sv
module cursor_ovl_hit
  import cursor_ovl_pkg::*;
(
  input  logic [CRD_W-1:0] cur_x,
  input  logic [CRD_W-1:0] cur_y,
  input  logic [CRD_W-1:0] scr_width,
  input  logic [CRD_W-1:0] vid_x,
  input  logic [CRD_W-1:0] vid_y,
  output logic             hit,
  output logic [IDX_W-1:0] row_idx,
  output logic [IDX_W-1:0] col_idx
);
  logic on_screen, col_in, row_in;

  assign on_screen = (cur_x < scr_width) && (vid_x < scr_width);
  assign col_in    = in_span(vid_x, cur_x);
  assign row_in    = in_span(vid_y, cur_y);
  assign hit       = on_screen && col_in && row_in;
  assign row_idx   = offs(vid_y, cur_y);
  assign col_idx   = offs(vid_x, cur_x);
endmodule

// File: rtl/cursor_ovl_mix.sv
module cursor_ovl_mix
  import cursor_ovl_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [IDX_W-1:0] col_idx,
  input  logic [CUR_N-1:0] mask_word,
  input  logic [CUR_N-1:0] bits_word,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [PIX_W-1:0] col_lo,
  input  logic [PIX_W-1:0] col_hi,
  output pix_sel_e         sel,
  output logic [PIX_W-1:0] pix_out
);
  always_comb begin
    sel = SEL_PASS;
    if (hit && msb_pick(mask_word, col_idx))
      sel = msb_pick(bits_word, col_idx) ? SEL_HI : SEL_LO;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_out <= '0;
    else begin
      unique case (sel)
        SEL_HI:  pix_out <= col_hi;
        SEL_LO:  pix_out <= col_lo;
        default: pix_out <= pix_in;
      endcase
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_ovl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PIX_W  = 24,
  parameter logic [ADDR_W-1:0] POS_OFF   = 12'h8fc,
  parameter logic [ADDR_W-1:0] MISC_OFF  = 12'h818,
  parameter logic [ADDR_W-1:0] MASK_BASE = 12'h900,
  parameter logic [ADDR_W-1:0] BITS_BASE = 12'h980
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CRD_W-1:0]  scr_width,
  input  logic [CRD_W-1:0]  vid_x,
  input  logic [CRD_W-1:0]  vid_y,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic [PIX_W-1:0]  cur_col_lo,
  input  logic [PIX_W-1:0]  cur_col_hi,
  output logic [PIX_W-1:0]  pix_out
);
  logic [CRD_W-1:0] cur_x, cur_y;
  logic [CUR_N-1:0] mask_word, bits_word;
  logic [IDX_W-1:0] row_idx, col_idx;
  logic             cur_hit;
  pix_sel_e         mix_sel;

  cursor_ovl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POS_OFF(POS_OFF), .MISC_OFF(MISC_OFF),
    .MASK_BASE(MASK_BASE), .BITS_BASE(BITS_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .row_sel(row_idx), .cur_x(cur_x), .cur_y(cur_y),
    .mask_word(mask_word), .bits_word(bits_word)
  );

  cursor_ovl_hit u_hit (
    .cur_x(cur_x), .cur_y(cur_y), .scr_width(scr_width), .vid_x(vid_x),
    .vid_y(vid_y), .hit(cur_hit), .row_idx(row_idx), .col_idx(col_idx)
  );

  cursor_ovl_mix #(.PIX_W(PIX_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .hit(cur_hit), .col_idx(col_idx),
    .mask_word(mask_word), .bits_word(bits_word), .pix_in(pix_in),
    .col_lo(cur_col_lo), .col_hi(cur_col_hi), .sel(mix_sel), .pix_out(pix_out)
  );
endmodule

// File: rtl/cursor_ovl_chk.sv
module cursor_ovl_chk
  import cursor_ovl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PIX_W  = 24,
  parameter logic [ADDR_W-1:0] MISC_OFF = 12'h818
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [CRD_W-1:0]  scr_width,
  input logic [CRD_W-1:0]  vid_x,
  input logic [CRD_W-1:0]  vid_y,
  input logic [PIX_W-1:0]  pix_in,
  input logic [PIX_W-1:0]  cur_col_lo,
  input logic [PIX_W-1:0]  cur_col_hi,
  input logic [PIX_W-1:0]  pix_out,
  input logic              cur_hit,
  input logic [CRD_W-1:0]  cur_x,
  input logic [CRD_W-1:0]  cur_y
);
  // R6 / R9: outside the cursor the next output is the pixel seen now
  p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_hit |=> pix_out == $past(pix_in));

  // R7: inside the cursor the output is a cursor colour or the pixel
  p_colour_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_hit |=> (pix_out == $past(cur_col_lo)) || (pix_out == $past(cur_col_hi))
                || (pix_out == $past(pix_in)));

  // R8: no cursor at or beyond the right edge
  p_clip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cur_hit |-> (vid_x < scr_width) && (cur_x < scr_width));

  // R4: rows covered are cur_y .. cur_y+31
  p_rows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_hit |-> (vid_y >= cur_y) && ({1'b0, vid_y} < {1'b0, cur_y} + 17'd32));

  // R2: status read always shows bit 25
  p_misc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == MISC_OFF) |-> reg_rdata[25]);

  // R10: other offsets read as zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != MISC_OFF) |-> reg_rdata == '0);
endmodule

bind cursor_overlay cursor_ovl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIX_W(PIX_W), .MISC_OFF(MISC_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .scr_width(scr_width), .vid_x(vid_x), .vid_y(vid_y), .pix_in(pix_in),
  .cur_col_lo(cur_col_lo), .cur_col_hi(cur_col_hi), .pix_out(pix_out),
  .cur_hit(cur_hit), .cur_x(cur_x), .cur_y(cur_y)
);

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] scr_width = 16'd100;
  logic [15:0] vid_x = '0, vid_y = '0;
  logic [23:0] pix_in = '0;
  logic [23:0] cur_col_lo = 24'hC0FFEE;
  logic [23:0] cur_col_hi = 24'h0BADF0;
  logic [23:0] pix_out;

  int errors = 0, checks = 0;
  int cx = 'hf000, cy = 0, wd = 100;
  bit done = 0;

  always #4 clk = ~clk;

  cursor_overlay dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scr_width(scr_width),
    .vid_x(vid_x), .vid_y(vid_y), .pix_in(pix_in), .cur_col_lo(cur_col_lo),
    .cur_col_hi(cur_col_hi), .pix_out(pix_out)
  );

  function automatic logic [31:0] mask_pat(int r);
    return 32'hA5C3_F00F ^ (32'(r) * 32'h0102_0408);
  endfunction
  function automatic logic [31:0] bits_pat(int r);
    return 32'h3C96_5AA5 + 32'(r) * 32'h1111_1111;
  endfunction
  function automatic logic [23:0] pix_of(int x, int y);
    return {8'h40, x[7:0], y[7:0]};
  endfunction

  function automatic logic [23:0] model(int x, int y, output string req);
    int dx, dy;
    dx = x - cx;
    dy = y - cy;
    req = "R6 R9";
    if (cx < wd && x < wd && dx >= 0 && dx < 32 && dy >= 0 && dy < 32) begin
      if (((mask_pat(dy) >> (31 - dx)) & 1) == 1) begin
        req = "R7 R5 R4";
        return (((bits_pat(dy) >> (31 - dx)) & 1) == 1) ? cur_col_hi : cur_col_lo;
      end
    end
    return pix_of(x, y);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic sweep(int x0, int x1, int y0, int y1, string tag);
    string req;
    logic [23:0] e;
    @(negedge clk);
    for (int y = y0; y <= y1; y++) begin
      for (int x = x0; x <= x1; x++) begin
        vid_x = 16'(x); vid_y = 16'(y); pix_in = pix_of(x, y);
        e = model(x, y, req);
        @(negedge clk);
        chk({tag, " ", req}, {8'h0, pix_out}, {8'h0, e});
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pix_out at reset", {8'h0, pix_out}, 32'h0);
    rst_n = 1'b1;
    rd_chk(12'h818, 32'h0200_0000, "R1 status after reset");
    // parked cursor: x=0xF000 so nothing shows
    sweep(0, 40, 0, 35, "R1 parked");
    wr(12'h818, 32'h0000_00A5);
    rd_chk(12'h818, 32'h0200_00A5, "R2 status low bits");
    wr(12'h818, 32'hFDFF_FFFF);
    rd_chk(12'h818, 32'hFFFF_FFFF, "R2 status bit25 forced");
    rd_chk(12'h900, 32'h0, "R10 mask offset reads zero");
    rd_chk(12'h8fc, 32'h0, "R10 position reads zero");
    for (int r = 0; r < 32; r++) begin
      wr(12'(12'h900 + 4 * r), mask_pat(r));
      wr(12'(12'h980 + 4 * r), bits_pat(r));
    end
    // R3: x in bits 31:16, y in bits 15:0; right-edge clip R8
    wr(12'h8fc, 32'h0050_000A);
    cx = 80; cy = 10;
    sweep(70, 110, 5, 45, "R3 R8 edge");
    // top-left placement, full width
    wr(12'h8fc, 32'h0004_0000);
    cx = 4; cy = 0;
    sweep(0, 40, 0, 35, "R3 R4 R5 full");
    // unmapped writes change nothing
    wr(12'h800, 32'hFFFF_FFFF);
    wr(12'h8f8, 32'h0000_0000);
    wr(12'hA00, 32'h0000_0000);
    sweep(0, 40, 0, 35, "R10 unmapped writes");
    // cursor x equal to width: clipped away entirely
    wr(12'h8fc, 32'h0064_0000);
    cx = 100; cy = 0;
    scr_width = 16'd100;
    sweep(90, 110, 0, 5, "R8 start at width");
    // narrower screen cuts the row short
    scr_width = 16'd20; wd = 20;
    wr(12'h8fc, 32'h0004_0002);
    cx = 4; cy = 2;
    sweep(0, 40, 0, 10, "R8 narrow");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule